// File: doc/BRIEF.md
# Flash Block-Erase Command Sequencer

This block sits behind the bus interface of a parallel flash device. It watches each byte write the host makes, as an address and a data byte. It recognises the six-write unlock pattern that requests a block erase. Five writes go to fixed low-order offsets with fixed data. The sixth write carries the erase code, and its address names the block to erase. When the pattern completes, the sequencer raises a one-cycle erase-start strobe and presents the captured block number. The erase engine downstream takes both.

A write that does not fit the next expected step discards the sequence. That write is then judged again as a possible opening step, so a host that starts over in the middle of a broken sequence is recognised at once. While the array reports busy, writes are ignored and the sequencer is held at its starting point.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `erase_go` is low, `erase_blk` is zero, and the sequencer waits for the first step.
- R2: Six accepted writes in order raise `erase_go` high for exactly one cycle, in the cycle after the sixth write. The writes are, by low 16 address bits and data: AAh to 5555h, 55h to 2AAAh, 80h to 5555h, AAh to 5555h, 55h to 2AAAh, and finally 50h to any address.
- R3: When `erase_go` is high, `erase_blk` equals address bits [ADDR_W-1:16] of the sixth write. `erase_blk` keeps that value until the next completed sequence.
- R4: For steps one to five, address bits at position 16 and above are not compared.
- R5: A write that matches neither the expected step nor step one returns the sequencer to step one, and no `erase_go` results from the broken sequence.
- R6: A mismatching write that is itself AAh to 5555h is taken as step one of a new sequence.
- R7: While `busy` is high, writes have no effect, and the partial sequence built before it is discarded.
- R8: Cycles with `wr_en` low neither advance nor break the sequence.
- R9: A sixth write whose data is not 50h completes nothing: `erase_go` stays low and `erase_blk` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | A byte write is presented this cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| busy | input | 1 | Array busy; writes are ignored while high |
| erase_go | output | 1 | One-cycle erase-start strobe |
| erase_blk | output | ADDR_W-16 | Block number captured from the sixth write |

## Verification
The bench goes after these corner cases:
- A restart in mid-sequence with AAh to 5555h. A design that merely clears its state would lose that opening write and never fire.
- Noisy upper address bits on the fixed steps. A design that compares too many bits would reject valid unlocks.
- A wrong data byte on the sixth write. Taking any data there would erase a block by accident.
- A busy pulse in mid-sequence. If the design kept its state through busy, a later tail could complete a pattern the array never fully accepted.
- Idle gaps between writes, and whether `erase_blk` holds its value between strobes.

A seeded random stream that is biased towards the correct next step is compared against a bench model on every cycle.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int ADDR_W = 24,
  parameter int BLK_LSB = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [7:0]                wr_data,
  input  logic                      busy,
  output logic                      erase_go,
  output logic [ADDR_W-BLK_LSB-1:0] erase_blk
);
  localparam logic [2:0] LAST = 3'd5;

  logic [2:0] step;
  logic       step_ok;

  wire [15:0] lo     = wr_addr[15:0];
  wire        at_a   = lo == 16'h5555;
  wire        at_b   = lo == 16'h2AAA;
  wire        open_w = at_a && wr_data == 8'hAA;
  wire        take   = wr_en && !busy;
  wire        done   = take && step_ok && step == LAST;

  always_comb begin
    case (step)
      3'd0:    step_ok = open_w;
      3'd1:    step_ok = at_b && wr_data == 8'h55;
      3'd2:    step_ok = at_a && wr_data == 8'h80;
      3'd3:    step_ok = open_w;
      3'd4:    step_ok = at_b && wr_data == 8'h55;
      3'd5:    step_ok = wr_data == 8'h50;
      default: step_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step      <= '0;
      erase_go  <= 1'b0;
      erase_blk <= '0;
    end else begin
      erase_go <= done;
      if (busy)
        step <= '0;
      else if (wr_en) begin
        if (done) begin
          step      <= '0;
          erase_blk <= wr_addr[ADDR_W-1:BLK_LSB];
        end else if (step_ok)
          step <= step + 3'd1;
        else
          step <= open_w ? 3'd1 : 3'd0;
      end
    end
  end
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int BLK_LSB = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         wr_addr,
  input logic [7:0]                wr_data,
  input logic                      busy,
  input logic                      erase_go,
  input logic [ADDR_W-BLK_LSB-1:0] erase_blk,
  input logic [2:0]                step
);
  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> !erase_go);
  // R9
  code_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> $past(wr_en && !busy && wr_data == 8'h50));
  // R3
  blk_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> erase_blk == $past(wr_addr[ADDR_W-1:BLK_LSB]));
  // R3
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_go |-> $stable(erase_blk));
  // R7
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> step == 3'd0 && !erase_go);
  // R8
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !busy) |=> $stable(step) && !erase_go);
  // R1
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step <= 3'd5);
endmodule

bind flash_erase_seq flash_erase_seq_chk #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .busy(busy), .erase_go(erase_go), .erase_blk(erase_blk), .step(step)
);

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;
  localparam int AW = 24;
  localparam int BW = AW - 16;

  logic clk = 0, rst_n = 0, wr_en = 0, busy = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic erase_go;
  logic [BW-1:0] erase_blk;

  int tests = 0, fails = 0;
  int m_step = 0;
  logic [BW-1:0] m_blk = '0;
  logic m_go = 0;

  always #2 clk = ~clk;

  flash_erase_seq #(.ADDR_W(AW), .BLK_LSB(16)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .erase_go(erase_go), .erase_blk(erase_blk));

  function automatic bit fits(int s, logic [AW-1:0] a, logic [7:0] d);
    case (s)
      0, 3: return a[15:0] == 16'h5555 && d == 8'hAA;
      1, 4: return a[15:0] == 16'h2AAA && d == 8'h55;
      2:    return a[15:0] == 16'h5555 && d == 8'h80;
      5:    return d == 8'h50;
      default: return 0;
    endcase
  endfunction

  function automatic void model(logic en, logic [AW-1:0] a, logic [7:0] d, logic b);
    m_go = 0;
    if (b) m_step = 0;
    else if (en) begin
      if (fits(m_step, a, d)) begin
        if (m_step == 5) begin m_go = 1; m_step = 0; m_blk = a[AW-1:16]; end
        else m_step++;
      end else m_step = fits(0, a, d) ? 1 : 0;
    end
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(string req, logic en, logic [AW-1:0] a, logic [7:0] d, logic b);
    wr_en = en; wr_addr = a; wr_data = d; busy = b;
    @(posedge clk);
    model(en, a, d, b);
    @(negedge clk);
    check(req, erase_go, m_go);
    check(req, erase_blk, m_blk);
  endtask

  task automatic unlock(string req, logic [7:0] up);
    cyc(req, 1, {up, 16'h5555}, 8'hAA, 0);
    cyc(req, 1, {up, 16'h2AAA}, 8'h55, 0);
    cyc(req, 1, {up, 16'h5555}, 8'h80, 0);
    cyc(req, 1, {up, 16'h5555}, 8'hAA, 0);
    cyc(req, 1, {up, 16'h2AAA}, 8'h55, 0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", erase_go, 0);
    check("R1", erase_blk, 0);
    rst_n = 1;

    unlock("R2", 8'h00);
    cyc("R2", 1, 24'h3A1234, 8'h50, 0);
    check("R2", erase_go, 1);
    check("R3", erase_blk, 8'h3A);
    cyc("R2", 0, '0, '0, 0);
    check("R2", erase_go, 0);
    check("R3", erase_blk, 8'h3A);

    unlock("R4", 8'hF7);
    cyc("R4", 1, 24'h510000, 8'h50, 0);
    check("R4", erase_go, 1);

    cyc("R8", 1, 24'h005555, 8'hAA, 0);
    cyc("R8", 0, 24'h002AAA, 8'h55, 0);
    cyc("R8", 1, 24'h002AAA, 8'h55, 0);
    cyc("R8", 0, '0, '0, 0);
    cyc("R8", 1, 24'h005555, 8'h80, 0);
    cyc("R8", 1, 24'h005555, 8'hAA, 0);
    cyc("R8", 1, 24'h002AAA, 8'h55, 0);
    cyc("R8", 0, '0, '0, 0);
    cyc("R8", 1, 24'h220000, 8'h50, 0);
    check("R8", erase_go, 1);

    cyc("R5", 1, 24'h005555, 8'hAA, 0);
    cyc("R5", 1, 24'h002AAA, 8'h55, 0);
    cyc("R5", 1, 24'h005555, 8'h81, 0);
    cyc("R5", 1, 24'h005555, 8'hAA, 0);
    cyc("R5", 1, 24'h002AAA, 8'h55, 0);
    cyc("R5", 1, 24'h990000, 8'h50, 0);
    check("R5", erase_go, 0);
    check("R5", erase_blk, 8'h22);

    cyc("R6", 1, 24'h005555, 8'hAA, 0);
    cyc("R6", 1, 24'h002AAA, 8'h55, 0);
    cyc("R6", 1, 24'h005555, 8'hAA, 0);
    cyc("R6", 1, 24'h002AAA, 8'h55, 0);
    cyc("R6", 1, 24'h005555, 8'h80, 0);
    cyc("R6", 1, 24'h005555, 8'hAA, 0);
    cyc("R6", 1, 24'h002AAA, 8'h55, 0);
    cyc("R6", 1, 24'h770000, 8'h50, 0);
    check("R6", erase_go, 1);
    check("R6", erase_blk, 8'h77);

    unlock("R7", 8'h00);
    cyc("R7", 0, '0, '0, 1);
    cyc("R7", 1, 24'h440000, 8'h50, 0);
    check("R7", erase_go, 0);
    cyc("R7", 1, 24'h005555, 8'hAA, 1);
    cyc("R7", 1, 24'h002AAA, 8'h55, 0);
    check("R7", erase_go, 0);

    unlock("R9", 8'h00);
    cyc("R9", 1, 24'h660000, 8'h30, 0);
    check("R9", erase_go, 0);
    check("R9", erase_blk, 8'h77);

    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      int r = $urandom_range(0, 99);
      int s = (r < 70) ? m_step : $urandom_range(0, 5);
      a = {8'($urandom), 16'($urandom)};
      d = 8'($urandom);
      case (s)
        0, 3: begin a[15:0] = 16'h5555; d = 8'hAA; end
        1, 4: begin a[15:0] = 16'h2AAA; d = 8'h55; end
        2:    begin a[15:0] = 16'h5555; d = 8'h80; end
        default: d = ($urandom_range(0, 9) == 0) ? d : 8'h50;
      endcase
      cyc("R2/R3 random", $urandom_range(0, 9) != 0, a, d, $urandom_range(0, 49) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule